// File: doc/BRIEF.md
# Chopped ADC output averager

This block sits between the decimation filter of a chopped sigma-delta converter and the data register that software reads. While chopping is on, it drives a polarity signal to the analog input switch and flips that signal once for every filter word. A chopped converter puts a residual offset into each word with a sign that alternates from word to word. The block adds each incoming word to the word that came just before it and halves the sum, so the offset cancels. The averaged value is loaded into a result register, a one-cycle strobe is raised, and a sticky ready flag is set. The ready flag stays set until the reader acknowledges it.

When the chop-off control is high, the polarity signal is held low and each filter word is copied straight into the result register. When chopping is turned back on, and also after reset, the block keeps the first new word only as the pairing partner. No result comes out until the second word arrives.

The controller has three states:
- `ST_PRIME`: chopping is on and no partner is held. This is the reset state.
- `ST_PAIR`: chopping is on and a partner is held.
- `ST_BYPASS`: chopping is off.

The transitions are:
- Any state goes to `ST_BYPASS` whenever chop-off is high.
- `ST_BYPASS` goes to `ST_PAIR` if a word arrives in the cycle chopping turns back on. Otherwise it goes to `ST_PRIME`.
- `ST_PRIME` goes to `ST_PAIR` on a word.
- `ST_PAIR` stays in `ST_PAIR` on every word and emits an average each time.

Top module: `chop_averager`

## Requirements
- R1: After reset (rst_n low at a rising edge), chop_pol, res_strobe and res_ready are 0 and res_data is 0.
- R2: With chop_off low, chop_pol inverts in the cycle after each accepted word (fw_valid high). It keeps its value in cycles without a word.
- R3: An average equals (previous word + current word) computed in DATA_W+1 bits, arithmetically shifted right by one (floor of half). It never overflows, even when both words are at the most positive value or both at the most negative value.
- R4: The first word accepted after reset, or after chop_off falls, produces no strobe and leaves res_data unchanged. The second word produces an average.
- R5: Averaging uses overlapping pairs: every word from the second one on is paired with the word immediately before it.
- R6: While chop_off is high, chop_pol is 0 from the next cycle onward. Each accepted word appears unchanged on res_data one cycle later, together with a strobe.
- R7: res_strobe is high for exactly one cycle per loaded result. res_ready is set in the same cycle.
- R8: rd_ack high clears res_ready on the next edge. If a result is loaded in the same cycle, the load wins and res_ready stays 1.
- R9: res_data holds its value in every cycle in which no result is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_data | input | DATA_W | Signed two's-complement filter word |
| fw_valid | input | 1 | Strobe: fw_data holds a new word this cycle |
| chop_off | input | 1 | Mode control: 1 disables chopping |
| rd_ack | input | 1 | Reader acknowledge; clears the ready flag |
| res_data | output | DATA_W | Result register |
| res_strobe | output | 1 | One-cycle pulse when a result is loaded |
| res_ready | output | 1 | Sticky flag: unread result present |
| chop_pol | output | 1 | Input polarity command for the front-end switch |

## Verification
The hardest situation to reach is a change of mode in the middle of a stream. One case is chopping turning back on in the same cycle that a word arrives, straight from `ST_BYPASS`. Another is a bypass interval that begins while the polarity is high. The stimulus table moves chop_off across those cycles deliberately, so the priming rule and the polarity return to 0 are both exercised. Directed steps then drive full-scale words of equal sign to stress the wide sum, and collide an acknowledge with a load to show which one wins.

// File: rtl/chop_avg_pkg.sv
package chop_avg_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_PRIME  = 2'd1,
        ST_PAIR   = 2'd2
    } chop_state_e;

endpackage

// File: rtl/chop_avg_fsm.sv
module chop_avg_fsm
    import chop_avg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chop_en,
    input  logic fw_valid,
    output logic chop_pol,
    output logic capture_prev,
    output logic emit_avg,
    output logic emit_raw
);

    chop_state_e state_q, state_nx;
    logic        pol_q, pol_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            pol_q   <= pol_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx     = state_q;
        pol_nx       = pol_q;
        capture_prev = 1'b0;
        emit_avg     = 1'b0;
        emit_raw     = 1'b0;
        if (!chop_en) begin
            state_nx = ST_BYPASS;
            pol_nx   = 1'b0;
            emit_raw = fw_valid;
        end else begin
            unique case (state_q)
                ST_BYPASS, ST_PRIME: begin
                    if (fw_valid) begin
                        capture_prev = 1'b1;
                        pol_nx       = ~pol_q;
                        state_nx     = ST_PAIR;
                    end else begin
                        state_nx     = ST_PRIME;
                    end
                end
                ST_PAIR: begin
                    if (fw_valid) begin
                        capture_prev = 1'b1;
                        emit_avg     = 1'b1;
                        pol_nx       = ~pol_q;
                    end
                end
                default: begin
                    state_nx = ST_PRIME;
                end
            endcase
        end
    end

    assign chop_pol = pol_q;

    // R2
    pol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_en && !fw_valid) |=> $stable(pol_q));

    // R4
    prime_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PAIR && chop_en && fw_valid) |=> (state_q == ST_PAIR));

endmodule

// File: rtl/chop_avg_math.sv
module chop_avg_math #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] avg
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] prev_q;
    logic [SUM_W-1:0]  sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (capture) begin
            prev_q <= din;
        end
    end

    always_comb begin
        sum = {prev_q[DATA_W-1], prev_q} + {din[DATA_W-1], din};
        avg = sum[SUM_W-1:1];
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (($signed(avg) >= $signed(prev_q)) || ($signed(avg) >= $signed(din)))
                 && (($signed(avg) <= $signed(prev_q)) || ($signed(avg) <= $signed(din))));

endmodule

// File: rtl/chop_avg_resreg.sv
module chop_avg_resreg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] res_data,
    output logic              res_strobe,
    output logic              res_ready
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data   <= '0;
            res_strobe <= 1'b0;
            res_ready  <= 1'b0;
        end else begin
            res_strobe <= load;
            if (load) begin
                res_data  <= load_val;
                res_ready <= 1'b1;
            end else if (rd_ack) begin
                res_ready <= 1'b0;
            end
        end
    end

    // R7
    stb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_strobe |-> res_ready);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !load) |=> !res_ready);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(res_data));

endmodule

// File: rtl/chop_averager.sv
module chop_averager #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] fw_data,
    input  logic              fw_valid,
    input  logic              chop_off,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] res_data,
    output logic              res_strobe,
    output logic              res_ready,
    output logic              chop_pol
);

    logic              chop_en;
    logic              capture_prev;
    logic              emit_avg;
    logic              emit_raw;
    logic [DATA_W-1:0] avg;
    logic [DATA_W-1:0] load_val;
    logic              load;

    assign chop_en = ~chop_off;

    chop_avg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chop_en      (chop_en),
        .fw_valid     (fw_valid),
        .chop_pol     (chop_pol),
        .capture_prev (capture_prev),
        .emit_avg     (emit_avg),
        .emit_raw     (emit_raw)
    );

    chop_avg_math #(.DATA_W(DATA_W)) u_math (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture_prev),
        .din     (fw_data),
        .avg     (avg)
    );

    assign load     = emit_avg | emit_raw;
    assign load_val = emit_raw ? fw_data : avg;

    chop_avg_resreg #(.DATA_W(DATA_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (load_val),
        .rd_ack     (rd_ack),
        .res_data   (res_data),
        .res_strobe (res_strobe),
        .res_ready  (res_ready)
    );

    // R2
    pol_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chop_off && fw_valid) |=> (chop_pol != $past(chop_pol)));

    // R6
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chop_off |=> !chop_pol);

    // R6
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_off && fw_valid) |=> (res_strobe && res_data == $past(fw_data)));

endmodule

// File: tb/chop_averager_tb.sv
module chop_averager_tb;

    localparam int W  = 16;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] fw_data;
    logic         fw_valid;
    logic         chop_off;
    logic         rd_ack;
    logic [W-1:0] res_data;
    logic         res_strobe;
    logic         res_ready;
    logic         chop_pol;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    chop_averager #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .fw_data(fw_data), .fw_valid(fw_valid),
        .chop_off(chop_off), .rd_ack(rd_ack), .res_data(res_data),
        .res_strobe(res_strobe), .res_ready(res_ready), .chop_pol(chop_pol)
    );

    // {chop_off, valid, din, exp_strobe, exp_data, exp_pol}
    localparam logic [35:0] VEC [0:NV-1] = '{
        {1'b0, 1'b1, 16'sd100,    1'b0, 16'sd0,      1'b1}, // R4 first word primes
        {1'b0, 1'b1, 16'sd110,    1'b1, 16'sd105,    1'b0}, // R3
        {1'b0, 1'b0, 16'sd0,      1'b0, 16'sd105,    1'b0}, // R2 R9 idle
        {1'b0, 1'b1, -16'sd10,    1'b1, 16'sd50,     1'b1}, // R5 overlap
        {1'b0, 1'b1, -16'sd21,    1'b1, -16'sd16,    1'b0}, // R3 floor
        {1'b1, 1'b1, 16'sd7,      1'b1, 16'sd7,      1'b0}, // R6
        {1'b1, 1'b1, -16'sd3,     1'b1, -16'sd3,     1'b0}, // R6
        {1'b0, 1'b1, 16'sd40,     1'b0, -16'sd3,     1'b1}, // R4 re-enable
        {1'b0, 1'b1, 16'sd60,     1'b1, 16'sd50,     1'b0},
        {1'b0, 1'b1, 16'sd20,     1'b1, 16'sd40,     1'b1},
        {1'b1, 1'b0, 16'sd0,      1'b0, 16'sd40,     1'b0}, // R6 pol to 0
        {1'b0, 1'b1, 16'sd1000,   1'b0, 16'sd40,     1'b1}, // R4
        {1'b0, 1'b1, 16'sd32767,  1'b1, 16'sd16883,  1'b0},
        {1'b0, 1'b1, 16'sd32767,  1'b1, 16'sd32767,  1'b1}, // R3 max
        {1'b0, 1'b1, -16'sd32768, 1'b1, -16'sd1,     1'b0},
        {1'b0, 1'b1, -16'sd32768, 1'b1, -16'sd32768, 1'b1}, // R3 min
        {1'b0, 1'b1, -16'sd1,     1'b1, -16'sd16385, 1'b0}, // R3 wide sum
        {1'b0, 1'b1, 16'sd2,      1'b1, 16'sd0,      1'b1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic co, input logic v, input logic [W-1:0] d, input logic ack);
        chop_off = co; fw_valid = v; fw_data = d; rd_ack = ack;
        @(negedge clk);
        fw_valid = 1'b0; rd_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        fw_data = '0; fw_valid = 1'b0; chop_off = 1'b0; rd_ack = 1'b0;
        @(negedge clk);
        do_reset();
        chk("R1", "pol", int'(chop_pol), 0);
        chk("R1", "strobe", int'(res_strobe), 0);
        chk("R1", "ready", int'(res_ready), 0);
        chk("R1", "data", int'($signed(res_data)), 0);

        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VEC[i];
            step(v[35], v[34], v[33:18], 1'b0);
            chk(v[17] ? "R7" : "R4", "strobe", int'(res_strobe), int'(v[17]));
            chk(v[17] ? "R3" : "R9", "data", int'($signed(res_data)), int'($signed(v[16:1])));
            chk(v[35] ? "R6" : "R2", "pol", int'(chop_pol), int'(v[0]));
            chk("R7", "ready", int'(res_ready), (i == 0) ? 0 : 1);
        end

        // R7 strobe lasts one cycle
        step(1'b0, 1'b0, '0, 1'b0);
        chk("R7", "strobe drops", int'(res_strobe), 0);
        chk("R7", "ready stays", int'(res_ready), 1);

        // R8 acknowledge clears the flag, data kept
        step(1'b0, 1'b0, '0, 1'b1);
        chk("R8", "ready after ack", int'(res_ready), 0);
        chk("R9", "data after ack", int'($signed(res_data)), 0);

        // R8 load wins over ack in the same cycle
        step(1'b1, 1'b1, 16'sd5, 1'b1);
        chk("R8", "ready on collide", int'(res_ready), 1);
        chk("R6", "data on collide", int'($signed(res_data)), 5);

        // R1 reset in mid stream, then R4 priming after reset
        step(1'b0, 1'b1, 16'sd300, 1'b0);
        do_reset();
        chk("R1", "data after reset", int'($signed(res_data)), 0);
        chk("R1", "ready after reset", int'(res_ready), 0);
        chk("R1", "pol after reset", int'(chop_pol), 0);
        step(1'b0, 1'b1, 16'sd8, 1'b0);
        chk("R4", "no strobe post reset", int'(res_strobe), 0);
        chk("R2", "pol post reset", int'(chop_pol), 1);
        step(1'b0, 1'b1, 16'sd4, 1'b0);
        chk("R4", "second word avg", int'($signed(res_data)), 6);
        chk("R2", "pol second", int'(chop_pol), 0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule